// File: doc/BRIEF.md
# SD Host Data-Phase Timeout and Byte Counter

This block holds the data-phase timing and length logic of an SD-card host data path. It runs in the card clock domain and keeps two programmable values: a 32-bit timeout period, counted in card clock cycles, and a 25-bit byte count. Software programs both values first and then issues the transfer-enable write. The block captures both values only on that enable write. The byte count becomes a live counter that steps down once for each transferred byte. The block reports the remaining count, whether a transfer is in progress and when it has completed.

The data-path state machine sits outside this block. It reports two conditions: waiting for the card to send data, and waiting while the card is busy. While either condition holds, a countdown runs from the captured timeout. If the countdown runs out before the path leaves those conditions, a sticky timeout flag is raised. In block mode a length that is not a whole number of blocks is refused, and a length-error flag is raised.

Top module: `sdxfer_tmo_len`

## Requirements
- R1: After reset, both register readbacks, the remaining count, `xfer_active`, `xfer_done`, `len_err` and `tmo_flag` are all zero.
- R2: A timeout write stores all 32 bits. A length write stores bits 24:0 only. `len_val_o` bits 31:25 always read zero.
- R3: An enable write captures the length and timeout register values held before that cycle. A register write in the same cycle as the enable does not affect the transfer being started.
- R4: One cycle after an accepted start, `remaining` equals the captured length. Each `byte_stb` cycle while `xfer_active` is high lowers `remaining` by one. A `byte_stb` while `xfer_active` is low has no effect.
- R5: On the edge where `remaining` reaches zero, `xfer_done` rises and `xfer_active` falls. A start with length zero gives `xfer_done`=1 and `xfer_active`=0 at once. `xfer_done` holds until the next accepted start.
- R6: With `blk_mode`=1, the block size is 2^`blk_log2` bytes. An enable write whose stored length has any of its low `blk_log2` bits set is refused: `len_err` rises, and the transfer state and the captured timeout are left unchanged. `len_err` stays high until the next accepted start. With `blk_mode`=0 no length check is made.
- R7: Let N be the captured timeout. `tmo_flag` rises on the edge that ends the (N+1)-th consecutive cycle in which `st_wait_rx` or `st_busy` is high. Moving between those two inputs does not restart the count.
- R8: With a captured timeout of zero, `tmo_flag` rises on the edge that ends the first counted cycle.
- R9: Leaving both counted states before expiry stops the count without raising `tmo_flag`. A later entry restarts the full count.
- R10: `tmo_flag` stays high until a `tmo_clr` cycle clears it on that edge. A new expiry in the same cycle as `tmo_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_we | input | 1 | Timeout register write strobe |
| tmo_wdata | input | 32 | Timeout write data |
| len_we | input | 1 | Length register write strobe |
| len_wdata | input | 32 | Length write data (bits 24:0 kept) |
| tmo_val_o | output | 32 | Timeout register readback |
| len_val_o | output | 32 | Length register readback |
| xfer_en_we | input | 1 | Transfer-enable write strobe |
| blk_mode | input | 1 | 1 = block transfer, 0 = stream |
| blk_log2 | input | 4 | Block size as log2 of bytes |
| byte_stb | input | 1 | One byte transferred this cycle |
| st_wait_rx | input | 1 | Data path waiting for card data |
| st_busy | input | 1 | Data path waiting on card busy |
| tmo_clr | input | 1 | Clears the timeout flag |
| tmo_flag | output | 1 | Sticky data timeout flag |
| len_err | output | 1 | Refused block-mode length |
| remaining | output | 25 | Bytes left in the transfer |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Transfer byte count exhausted |

## Verification
A corrupted countdown shows at only one port, `tmo_flag`. It appears as an expiry one or more cycles early or late, and only at the end of a long enough wait. For that reason the reference model is compared on every clock across runs of waiting cycles that are both broken and unbroken. A wrong data counter shows on `remaining` on the next clock edge. A missed zero detect leaves `xfer_active` high past zero within one cycle. A wrong capture at enable time shows at once in `remaining`, but in the timeout only when the next wait expires.

// File: rtl/sdxfer_pkg.sv
package sdxfer_pkg;
   localparam int unsigned SDX_BUS_W = 32;
   localparam int unsigned SDX_TMO_W = 32;
   localparam int unsigned SDX_LEN_W = 25;
   localparam int unsigned SDX_BSZ_W = 4;

   typedef struct packed {
      logic active;
      logic done;
      logic len_err;
   } xfer_stat_t;
endpackage

// File: rtl/sdxfer_tmo_cnt.sv
module sdxfer_tmo_cnt #(
   parameter int unsigned TMO_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             counted,
   input  logic [TMO_W-1:0] period,
   input  logic             clr,
   output logic             flag
);
   logic             was_counted;
   logic [TMO_W-1:0] tcnt;
   logic             entry;
   logic             expire;

   assign entry  = counted & ~was_counted;
   assign expire = counted & (entry ? (period == '0) : (tcnt == TMO_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         was_counted <= 1'b0;
         tcnt        <= '0;
         flag        <= 1'b0;
      end else begin
         was_counted <= counted;
         if (entry)
            tcnt <= period;
         else if (counted && tcnt != '0)
            tcnt <= tcnt - TMO_W'(1);
         flag <= expire | (flag & ~clr);
      end
   end

   // R7: a countdown reaching zero inside a counted run sets the flag
   a_r7_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (counted && was_counted && tcnt == TMO_W'(1)) |=> flag);
   // R8: a zero period expires on the entry cycle
   a_r8_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      (counted && !was_counted && period == '0) |=> flag);
   // R9: outside the counted states the countdown is frozen
   a_r9_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !counted |=> $stable(tcnt));
   // R10: the flag is sticky until cleared
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/sdxfer_len_cnt.sv
module sdxfer_len_cnt
   import sdxfer_pkg::*;
#(
   parameter int unsigned LEN_W       = 25,
   parameter int unsigned BSZ_W       = 4,
   parameter bit          BLK_CHECK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_we,
   input  logic             blk_mode,
   input  logic [BSZ_W-1:0] blk_log2,
   input  logic [LEN_W-1:0] len_i,
   input  logic             byte_stb,
   output logic             accept,
   output logic [LEN_W-1:0] remaining,
   output xfer_stat_t       stat
);
   logic [LEN_W-1:0] low_mask;
   logic             misal;

   generate
      for (genvar gi = 0; gi < LEN_W; gi++) begin : g_mask
         assign low_mask[gi] = (32'(gi) < 32'(blk_log2));
      end
      if (BLK_CHECK_EN) begin : g_chk
         assign misal = blk_mode & (|(len_i & low_mask));
      end else begin : g_nochk
         assign misal = 1'b0;
      end
   endgenerate

   assign accept = start_we & ~misal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remaining <= '0;
         stat      <= '0;
      end else if (accept) begin
         remaining    <= len_i;
         stat.active  <= (len_i != '0);
         stat.done    <= (len_i == '0);
         stat.len_err <= 1'b0;
      end else begin
         if (start_we)
            stat.len_err <= 1'b1;
         if (stat.active && byte_stb) begin
            remaining <= remaining - LEN_W'(1);
            if (remaining == LEN_W'(1)) begin
               stat.active <= 1'b0;
               stat.done   <= 1'b1;
            end
         end
      end
   end

   // R4: an active transfer never shows a zero count
   a_r4_active_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      stat.active |-> (remaining != '0));
   // R4: each byte while active steps the count by one
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (stat.active && byte_stb && !start_we) |=> (remaining == $past(remaining) - LEN_W'(1)));
   // R5: done and active never coexist
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat.active && stat.done));
   // R6: a refused start leaves the count alone and flags the error
   a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (start_we && !accept && !byte_stb) |=> ($stable(remaining) && stat.len_err));
endmodule

// File: rtl/sdxfer_tmo_len.sv
module sdxfer_tmo_len
   import sdxfer_pkg::*;
#(
   parameter int unsigned BUS_W        = SDX_BUS_W,
   parameter int unsigned TMO_W        = SDX_TMO_W,
   parameter int unsigned LEN_W        = SDX_LEN_W,
   parameter int unsigned BSZ_W        = SDX_BSZ_W,
   parameter bit          BLK_CHECK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmo_we,
   input  logic [BUS_W-1:0] tmo_wdata,
   input  logic             len_we,
   input  logic [BUS_W-1:0] len_wdata,
   output logic [BUS_W-1:0] tmo_val_o,
   output logic [BUS_W-1:0] len_val_o,
   input  logic             xfer_en_we,
   input  logic             blk_mode,
   input  logic [BSZ_W-1:0] blk_log2,
   input  logic             byte_stb,
   input  logic             st_wait_rx,
   input  logic             st_busy,
   input  logic             tmo_clr,
   output logic             tmo_flag,
   output logic             len_err,
   output logic [LEN_W-1:0] remaining,
   output logic             xfer_active,
   output logic             xfer_done
);
   localparam int unsigned LEN_PAD = BUS_W - LEN_W;

   generate
      if (LEN_W > BUS_W || LEN_W < 1) begin : g_bad_len
         $error("sdxfer_tmo_len: LEN_W must be 1..BUS_W");
      end
      if (TMO_W > BUS_W || TMO_W < 2) begin : g_bad_tmo
         $error("sdxfer_tmo_len: TMO_W must be 2..BUS_W");
      end
      if (BSZ_W < 1 || BSZ_W > 5) begin : g_bad_bsz
         $error("sdxfer_tmo_len: BSZ_W must be 1..5");
      end
   endgenerate

   logic [TMO_W-1:0] tmo_reg;
   logic [LEN_W-1:0] len_reg;
   logic [TMO_W-1:0] tmo_snap;
   logic             accept;
   xfer_stat_t       stat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmo_reg  <= '0;
         len_reg  <= '0;
         tmo_snap <= '0;
      end else begin
         if (tmo_we) tmo_reg <= tmo_wdata[TMO_W-1:0];
         if (len_we) len_reg <= len_wdata[LEN_W-1:0];
         if (accept) tmo_snap <= tmo_reg;
      end
   end

   generate
      if (TMO_W == BUS_W) begin : g_tmo_full
         assign tmo_val_o = tmo_reg;
      end else begin : g_tmo_pad
         assign tmo_val_o = {{(BUS_W-TMO_W){1'b0}}, tmo_reg};
      end
      if (LEN_PAD == 0) begin : g_len_full
         assign len_val_o = len_reg;
      end else begin : g_len_pad
         assign len_val_o = {{LEN_PAD{1'b0}}, len_reg};
      end
   endgenerate

   sdxfer_len_cnt #(
      .LEN_W(LEN_W), .BSZ_W(BSZ_W), .BLK_CHECK_EN(BLK_CHECK_EN)
   ) i_len (
      .clk(clk), .rst_n(rst_n), .start_we(xfer_en_we), .blk_mode(blk_mode),
      .blk_log2(blk_log2), .len_i(len_reg), .byte_stb(byte_stb),
      .accept(accept), .remaining(remaining), .stat(stat)
   );

   sdxfer_tmo_cnt #(.TMO_W(TMO_W)) i_tmo (
      .clk(clk), .rst_n(rst_n), .counted(st_wait_rx | st_busy),
      .period(tmo_snap), .clr(tmo_clr), .flag(tmo_flag)
   );

   assign xfer_active = stat.active;
   assign xfer_done   = stat.done;
   assign len_err     = stat.len_err;

   // R3: the captured timeout changes only on an accepted start
   a_r3_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(tmo_snap));
   // R2: reserved length bits never read back set
   a_r2_len_pad: assert property (@(posedge clk) disable iff (!rst_n)
      len_val_o[BUS_W-1:LEN_W] == '0);
endmodule

// File: tb/test_sdxfer_tmo_len.sv
module test_sdxfer_tmo_len;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tmo_we = 0, len_we = 0, xfer_en_we = 0, blk_mode = 0;
   logic [31:0] tmo_wdata = 0, len_wdata = 0;
   logic [3:0]  blk_log2 = 0;
   logic        byte_stb = 0, st_wait_rx = 0, st_busy = 0, tmo_clr = 0;
   logic [31:0] tmo_val_o, len_val_o;
   logic        tmo_flag, len_err, xfer_active, xfer_done;
   logic [24:0] remaining;

   int checks = 0, fails = 0;
   bit finished = 0, cmp_on = 0;

   // behavioural reference state
   longint m_tmo, m_len, m_snap, m_rem, m_run, m_entry_n;
   bit m_act, m_done, m_lerr, m_flag;

   always #10 clk = ~clk;

   sdxfer_tmo_len i_sdxfer_tmo_len (
      .clk(clk), .rst_n(rst_n), .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
      .len_we(len_we), .len_wdata(len_wdata), .tmo_val_o(tmo_val_o),
      .len_val_o(len_val_o), .xfer_en_we(xfer_en_we), .blk_mode(blk_mode),
      .blk_log2(blk_log2), .byte_stb(byte_stb), .st_wait_rx(st_wait_rx),
      .st_busy(st_busy), .tmo_clr(tmo_clr), .tmo_flag(tmo_flag),
      .len_err(len_err), .remaining(remaining), .xfer_active(xfer_active),
      .xfer_done(xfer_done)
   );

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      longint n_tmo, n_len, n_snap, n_rem;
      bit n_act, n_done, n_lerr, set, bad;
      n_tmo = m_tmo; n_len = m_len; n_snap = m_snap; n_rem = m_rem;
      n_act = m_act; n_done = m_done; n_lerr = m_lerr; set = 0;
      if (!rst_n) begin
         m_tmo = 0; m_len = 0; m_snap = 0; m_rem = 0; m_run = 0; m_entry_n = 0;
         m_act = 0; m_done = 0; m_lerr = 0; m_flag = 0;
      end else begin
         if (tmo_we) n_tmo = tmo_wdata;
         if (len_we) n_len = len_wdata & 32'h01FF_FFFF;
         bad = blk_mode && ((m_len % (64'd1 << blk_log2)) != 0);
         if (xfer_en_we && !bad) begin
            n_snap = m_tmo; n_rem = m_len; n_act = (m_len != 0);
            n_done = (m_len == 0); n_lerr = 0;
         end else begin
            if (xfer_en_we) n_lerr = 1;
            if (m_act && byte_stb) begin
               n_rem = m_rem - 1;
               if (n_rem == 0) begin n_act = 0; n_done = 1; end
            end
         end
         if (st_wait_rx || st_busy) begin
            if (m_run == 0) m_entry_n = m_snap;
            m_run++;
            if (m_run == m_entry_n + 1) set = 1;
         end else m_run = 0;
         m_flag = set || (m_flag && !tmo_clr);
         m_tmo = n_tmo; m_len = n_len; m_snap = n_snap; m_rem = n_rem;
         m_act = n_act; m_done = n_done; m_lerr = n_lerr;
      end
   end

   always @(negedge clk) if (cmp_on && !finished) begin
      check("R2 tmo readback", tmo_val_o, m_tmo);
      check("R2 len readback", len_val_o, m_len);
      check("R4 remaining", remaining, m_rem);
      check("R5 active", xfer_active, m_act);
      check("R5 done", xfer_done, m_done);
      check("R6 len_err", len_err, m_lerr);
      check("R7 tmo_flag", tmo_flag, m_flag);
   end

   task automatic tick;
      @(negedge clk); #2;
      tmo_we = 0; len_we = 0; xfer_en_we = 0; byte_stb = 0; tmo_clr = 0;
   endtask

   task automatic wr_regs(longint t, longint l);
      tmo_we = 1; tmo_wdata = 32'(t); len_we = 1; len_wdata = 32'(l); tick();
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1;
      cmp_on = 1;
      tick();
      // R1: reset state
      check("R1 outputs", {tmo_val_o, len_val_o, 7'(remaining), tmo_flag, len_err, xfer_active, xfer_done}, 0);
      // R2: reserved length bits drop
      wr_regs(5, 64'hFFFF_FFFF);
      check("R2 len mask", len_val_o, 32'h01FF_FFFF);
      wr_regs(5, 10);
      // R3: same-cycle writes do not reach this transfer
      xfer_en_we = 1; len_we = 1; len_wdata = 3; tmo_we = 1; tmo_wdata = 7; tick();
      check("R3 captured length", remaining, 10);
      // R4: byte steps with gaps
      repeat (4) begin byte_stb = 1; tick(); end
      tick(); tick();
      check("R4 after four bytes", remaining, 6);
      repeat (6) begin byte_stb = 1; tick(); end
      check("R5 done at zero", {xfer_done, xfer_active}, 2'b10);
      byte_stb = 1; tick();
      check("R4 idle byte ignored", remaining, 0);
      // R9: broken wait does not time out (captured N=5)
      st_wait_rx = 1; repeat (3) tick();
      st_wait_rx = 0; tick();
      check("R9 no flag after early exit", tmo_flag, 0);
      // R7: six consecutive counted cycles, switching states
      st_wait_rx = 1; repeat (3) tick();
      st_wait_rx = 0; st_busy = 1; repeat (2) tick();
      check("R7 not yet", tmo_flag, 0);
      tick();
      check("R7 expiry", tmo_flag, 1);
      st_busy = 0; tick(); tick();
      check("R10 sticky", tmo_flag, 1);
      tmo_clr = 1; tick();
      check("R10 cleared", tmo_flag, 0);
      // R8: zero period
      wr_regs(0, 8);
      xfer_en_we = 1; tick();
      st_busy = 1; tick();
      check("R8 immediate expiry", tmo_flag, 1);
      st_busy = 0; tmo_clr = 1; tick();
      // R6: misaligned block length refused
      blk_mode = 1; blk_log2 = 3; len_we = 1; len_wdata = 12; tick();
      xfer_en_we = 1; tick();
      check("R6 refused", {len_err, 25'(remaining), xfer_active}, {1'b1, 25'd8, 1'b1});
      len_we = 1; len_wdata = 16; tick();
      xfer_en_we = 1; tick();
      check("R6 accepted aligned", {len_err, 25'(remaining)}, {1'b0, 25'd16});
      // R5: zero length start
      blk_mode = 0; len_we = 1; len_wdata = 0; tick();
      xfer_en_we = 1; tick();
      check("R5 zero length", {xfer_done, xfer_active}, 2'b10);
      // mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         byte_stb   = ($urandom_range(0, 1) == 1);
         st_wait_rx = ($urandom_range(0, 9) < 4);
         st_busy    = ($urandom_range(0, 9) < 3);
         tmo_clr    = ($urandom_range(0, 19) == 0);
         blk_mode   = ($urandom_range(0, 1) == 1);
         blk_log2   = 4'($urandom_range(0, 3));
         if ($urandom_range(0, 14) == 0) begin
            tmo_we = 1; tmo_wdata = $urandom_range(0, 6);
         end
         if ($urandom_range(0, 14) == 0) begin
            len_we = 1; len_wdata = $urandom_range(0, 40);
         end
         xfer_en_we = ($urandom_range(0, 24) == 0);
         tick();
      end
      st_wait_rx = 0; st_busy = 0;
      tick();
      finish_run();
   end
endmodule